// File: doc/BRIEF.md
# I2C Read-Only Slave with Clock Stretching

This block is a 7-bit-address I2C slave that answers master read transactions. It samples the open-drain SCL and SDA lines through two-stage synchronisers and finds bus events on those samples. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. After a START the first byte is compared against a programmable slave address. An all-zero general-call address can also be accepted when enabled. If the address hits and the direction bit requests a read, the block acknowledges the address. It then serves data bytes from a one-byte transmit register that software fills.

When the slave must send a byte and the transmit register is empty, it holds SCL low until software writes the register. This happens just after the address acknowledge and at the start of each later byte. The empty flag is raised once the most significant bit of the current byte has been clocked out. Software therefore has most of a byte time to supply the next value. Status flags and two interrupt lines report the events to software:
- an address hit, with the direction of the transfer,
- a Not Acknowledge from the master,
- a STOP or repeated START that ends an addressed transfer.

Both bus outputs are pull-low enables: a 1 drives the wire low, and a 0 releases it.

Top module: `i2c_rd_slave`

## Requirements
- R1: The address byte is sent as 7 address bits, most significant bit first, followed by the direction bit (1 = read). The slave drives SDA low in the ninth clock only when the 7 bits equal `own_addr` and the direction bit is 1. Any other address, and a write to `own_addr`, is left unacknowledged (SDA high in the ninth clock).
- R2: On the eighth SCL rising edge of an address byte that hits, `st_match` goes to 1 and `st_read` takes the direction bit; `irq_status` follows. `st_read` is never 1 while `st_match` is 0.
- R3: After acknowledging a read address with the transmit register empty, the slave holds SCL low (`scl_oe` = 1) until `wr_en` loads the register. It releases SCL a fixed setup time after the load.
- R4: Data bytes appear on SDA most significant bit first. SDA is only changed while SCL is low.
- R5: `st_empty` goes to 1 after the SCL falling edge that ends the first (most significant) bit of a byte. `irq_tx` equals `st_empty` AND `txi_en` at all times, and `st_empty` is 1 after reset.
- R6: A `wr_en` pulse loads `wr_data` and clears `st_empty`. A `flush` pulse sets `st_empty`, and `flush` wins over a `wr_en` in the same cycle.
- R7: When the master pulls SCL low after acknowledging a byte, the slave does one of two things. With the register full, it starts the next byte without holding SCL. With the register empty, it holds SCL low until the register is written.
- R8: A Not Acknowledge (SDA high) in the ninth clock after a data byte sets `st_nak` and `irq_status`. The slave then leaves SDA released.
- R9: A STOP or a repeated START that follows an acknowledged read address sets `st_stop`. STOP or START with no acknowledged read address in progress leaves it at 0.
- R10: With `gc_en` = 1, address 0 with direction bit 1 is acknowledged and served like `own_addr`. With `gc_en` = 0 it is not acknowledged.
- R11: A `clr_flags` pulse clears `st_match`, `st_read`, `st_nak` and `st_stop`. A flag set in the same cycle stays set.
- R12: After reset, both pull-low outputs are 0, `st_empty` = 1 and all other flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL wire |
| sda_i | input | 1 | Level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Programmable slave address |
| gc_en | input | 1 | Also accept the general-call address |
| txi_en | input | 1 | Transmit interrupt enable |
| wr_en | input | 1 | One-cycle write strobe for the transmit register |
| wr_data | input | 8 | Byte to load into the transmit register |
| flush | input | 1 | One-cycle strobe that empties the transmit register |
| clr_flags | input | 1 | One-cycle strobe that clears the event flags |
| st_match | output | 1 | Address hit seen |
| st_read | output | 1 | Direction bit of the last hit |
| st_empty | output | 1 | Transmit register empty |
| st_nak | output | 1 | Master answered a data byte with Not Acknowledge |
| st_stop | output | 1 | Addressed transfer ended by STOP or repeated START |
| irq_tx | output | 1 | Transmit interrupt |
| irq_status | output | 1 | Event interrupt (hit, NAK or stop) |

## Verification
A wrong bus-state register shows as a wrong wire level within one SCL half period. It appears as a missing or spurious acknowledge, a data bit out of order, or SCL held low when it should be free, or free when it should be held. A wrong bit counter shifts every later byte, so the received value is wrong at the end of that byte. A wrong fill state of the transmit register shows at once on `st_empty` and `irq_tx`. On the bus it shows at the next byte start as a missing or needless stretch. The reference model predicts each received byte, each acknowledge level and each flag at fixed points in the transfer. Per clock, it checks the interrupt lines and that SDA moves only while SCL is low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADEC,
        ST_AACK_LO,
        ST_AACK_HI,
        ST_STRETCH,
        ST_SETUP,
        ST_TX,
        ST_MACK,
        ST_GAP,
        ST_SKIP
    } bus_state_t;

    // one-cycle event pulses from the bus engine to the flag register
    typedef struct packed {
        logic hit;
        logic rw;
        logic nak;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic match;
        logic read;
        logic nak;
        logic stop;
    } st_flags_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);

    typedef struct packed {
        logic [LINES-1:0][STAGES-1:0] pipe;
        logic [LINES-1:0]             prev;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < LINES; i++) begin
            r_d.pipe[i] = {r_q.pipe[i][STAGES-2:0], raw_i[i]};
            r_d.prev[i] = r_q.pipe[i][STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '1;   // idle bus is high
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign lvl_o[g]  = r_q.pipe[g][STAGES-1];
        assign rise_o[g] = r_q.pipe[g][STAGES-1] & ~r_q.prev[g];
        assign fall_o[g] = ~r_q.pipe[g][STAGES-1] & r_q.prev[g];
    end

endmodule

// File: rtl/i2cs_txbuf.sv
module i2cs_txbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          flush,
    input  logic          consume,
    output logic [DW-1:0] data_o,
    output logic          full_o
);

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } buf_regs_t;

    buf_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (flush) begin
            r_d.full = 1'b0;
        end else if (wr_en) begin
            r_d.full = 1'b1;
            r_d.data = wr_data;
        end else if (consume) begin
            r_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_o = r_q.data;
    assign full_o = r_q.full;

endmodule

// File: rtl/i2cs_flags.sv
module i2cs_flags
    import i2cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_ev_t   ev,
    input  logic      clr,
    output st_flags_t flags_o
);

    st_flags_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) r_d = '0;
        if (ev.hit) begin
            r_d.match = 1'b1;
            r_d.read  = ev.rw;
        end
        if (ev.nak)  r_d.nak  = 1'b1;
        if (ev.stop) r_d.stop = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags_o = r_q;

endmodule

// File: rtl/i2cs_bus.sv
module i2cs_bus
    import i2cs_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SETUP_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          sda_rise,
    input  logic          sda_fall,
    input  logic [DW-2:0] own_addr,
    input  logic          gc_en,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_data,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          consume,
    output bus_ev_t       ev
);

    localparam int AW = DW - 1;
    localparam int CW = $clog2(DW);
    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam logic [CW-1:0] LAST_BIT  = CW'(DW - 1);
    localparam logic [SW-1:0] SETUP_END = SW'(SETUP_CYC - 1);
    localparam logic [AW-1:0] GCALL     = '0;

    typedef struct packed {
        bus_state_t    state;
        logic [DW-1:0] sh;
        logic [CW-1:0] cnt;
        logic [SW-1:0] scnt;
        logic          ack_oe;
        logic          dat_en;
        logic          scl_oe;
        logic          active;
        logic          hit;
    } bus_regs_t;

    bus_regs_t     r_d, r_q;
    logic          start_c, stop_c, addr_hit, do_fetch;
    logic [DW-1:0] byte_in;

    always_comb begin
        r_d      = r_q;
        ev       = '0;
        consume  = 1'b0;
        do_fetch = 1'b0;
        start_c  = sda_fall & scl_lvl;
        stop_c   = sda_rise & scl_lvl;
        byte_in  = {r_q.sh[DW-2:0], sda_lvl};
        addr_hit = (byte_in[DW-1:1] == own_addr) ||
                   (gc_en && (byte_in[DW-1:1] == GCALL));

        if (start_c || stop_c) begin
            ev.stop     = r_q.active;
            r_d.state   = stop_c ? ST_IDLE : ST_ADDR;
            r_d.active  = 1'b0;
            r_d.ack_oe  = 1'b0;
            r_d.dat_en  = 1'b0;
            r_d.scl_oe  = 1'b0;
            r_d.hit     = 1'b0;
            r_d.cnt     = '0;
        end else begin
            case (r_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh  = byte_in;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == LAST_BIT) begin
                            ev.hit    = addr_hit;
                            ev.rw     = byte_in[0];
                            r_d.hit   = addr_hit & byte_in[0];
                            r_d.state = ST_ADEC;
                        end
                    end
                end
                ST_ADEC: begin
                    if (scl_fall) begin
                        if (r_q.hit) begin
                            r_d.ack_oe = 1'b1;
                            r_d.active = 1'b1;
                            r_d.state  = ST_AACK_LO;
                        end else begin
                            r_d.state = ST_SKIP;
                        end
                    end
                end
                ST_AACK_LO: begin
                    if (scl_rise) r_d.state = ST_AACK_HI;
                end
                ST_AACK_HI: begin
                    if (scl_fall) do_fetch = 1'b1;
                end
                ST_STRETCH: begin
                    if (tx_full) begin
                        r_d.sh     = tx_data;
                        r_d.dat_en = 1'b1;
                        r_d.scnt   = '0;
                        r_d.state  = ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    r_d.scnt = r_q.scnt + 1'b1;
                    if (r_q.scnt == SETUP_END) begin
                        r_d.scl_oe = 1'b0;
                        r_d.state  = ST_TX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == '0) consume = 1'b1;
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.dat_en = 1'b0;
                            r_d.state  = ST_MACK;
                        end else begin
                            r_d.sh  = {r_q.sh[DW-2:0], 1'b0};
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            ev.nak    = 1'b1;
                            r_d.state = ST_SKIP;
                        end else begin
                            r_d.state = ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (scl_fall) do_fetch = 1'b1;
                end
                default: ;
            endcase

            if (do_fetch) begin
                r_d.ack_oe = 1'b0;
                r_d.cnt    = '0;
                if (tx_full) begin
                    r_d.sh     = tx_data;
                    r_d.dat_en = 1'b1;
                    r_d.state  = ST_TX;
                end else begin
                    r_d.dat_en = 1'b0;
                    r_d.scl_oe = 1'b1;
                    r_d.state  = ST_STRETCH;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe = r_q.scl_oe;
    assign sda_oe = r_q.ack_oe | (r_q.dat_en & ~r_q.sh[DW-1]);

endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
    import i2cs_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SYNC_FF   = 2,
    parameter int SETUP_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic [DW-2:0] own_addr,
    input  logic          gc_en,
    input  logic          txi_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          flush,
    input  logic          clr_flags,
    output logic          st_match,
    output logic          st_read,
    output logic          st_empty,
    output logic          st_nak,
    output logic          st_stop,
    output logic          irq_tx,
    output logic          irq_status
);

    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;

    logic [1:0]    lvl, rise, fall;
    logic          tx_full, consume;
    logic [DW-1:0] tx_data;
    bus_ev_t       ev;
    st_flags_t     flags;

    i2cs_sync #(.LINES(2), .STAGES(SYNC_FF)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    i2cs_txbuf #(.DW(DW)) u_txbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flush   (flush),
        .consume (consume),
        .data_o  (tx_data),
        .full_o  (tx_full)
    );

    i2cs_bus #(.DW(DW), .SETUP_CYC(SETUP_CYC)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (lvl[LN_SCL]),
        .scl_rise (rise[LN_SCL]),
        .scl_fall (fall[LN_SCL]),
        .sda_lvl  (lvl[LN_SDA]),
        .sda_rise (rise[LN_SDA]),
        .sda_fall (fall[LN_SDA]),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .tx_full  (tx_full),
        .tx_data  (tx_data),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .consume  (consume),
        .ev       (ev)
    );

    i2cs_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .clr     (clr_flags),
        .flags_o (flags)
    );

    assign st_match   = flags.match;
    assign st_read    = flags.read;
    assign st_nak     = flags.nak;
    assign st_stop    = flags.stop;
    assign st_empty   = ~tx_full;
    assign irq_tx     = ~tx_full & txi_en;
    assign irq_status = flags.match | flags.nak | flags.stop;

endmodule

// File: rtl/i2c_rd_slave_chk.sv
module i2c_rd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic wr_en,
    input logic flush,
    input logic st_match,
    input logic st_read,
    input logic st_empty
);

    // R4: the slave moves SDA only while SCL is low
    p_sda_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R3 / R7: a stretch begins only when the register was empty
    p_stretch_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(st_empty));

    // R6: a write without flush fills the register
    p_write_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> !st_empty);

    // R6: flush empties the register, even against a write
    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_empty);

    // R2: direction flag only with an address hit
    p_read_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_read |-> st_match);

endmodule

bind i2c_rd_slave i2c_rd_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .flush    (flush),
    .st_match (st_match),
    .st_read  (st_read),
    .st_empty (st_empty)
);

// File: tb/i2c_rd_slave_test.sv
`timescale 1ns/1ps
module i2c_rd_slave_test;

    localparam int HALF = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_oe, sda_oe;
    logic [6:0] own_addr = 7'h5A;
    logic       gc_en = 1'b0, txi_en = 1'b0, wr_en = 1'b0, flush = 1'b0, clr_flags = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       st_match, st_read, st_empty, st_nak, st_stop, irq_tx, irq_status;
    logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    logic       scl_bus, sda_bus;

    int total = 0, bad = 0;
    int sda_viol = 0, irq_viol = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign scl_bus = !(m_scl_lo || scl_oe);
    assign sda_bus = !(m_sda_lo || sda_oe);

    i2c_rd_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
        .txi_en(txi_en), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
        .clr_flags(clr_flags), .st_match(st_match), .st_read(st_read),
        .st_empty(st_empty), .st_nak(st_nak), .st_stop(st_stop),
        .irq_tx(irq_tx), .irq_status(irq_status)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock model of the interrupt lines and the SDA timing rule
    logic prev_sda_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== prev_sda_oe && scl_bus) sda_viol++;
            if (irq_tx !== (st_empty && txi_en)) irq_viol++;
            if (irq_status !== (st_match || st_nak || st_stop)) irq_viol++;
        end
        prev_sda_oe = sda_oe;
    end

    task automatic sw_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b; exp_q.push_back(b);
        wcyc(1);
        wr_en = 1'b0;
    endtask

    task automatic sw_flush();
        flush = 1'b1;
        if (exp_q.size() > 0) void'(exp_q.pop_back());
        wcyc(1);
        flush = 1'b0;
    endtask

    task automatic sw_clear();
        clr_flags = 1'b1; wcyc(1); clr_flags = 1'b0; wcyc(1);
    endtask

    task automatic clk_high(output int st);
        m_scl_lo = 1'b0;
        st = 0;
        while (!scl_bus && st < 5000) begin
            wcyc(1);
            st++;
        end
    endtask

    task automatic send_bit(input logic b);
        int st;
        m_sda_lo = !b;
        wcyc(HALF);
        clk_high(st);
        wcyc(HALF);
        m_scl_lo = 1'b1;
    endtask

    task automatic recv_bit(output logic b, output int st);
        m_sda_lo = 1'b0;
        wcyc(HALF);
        clk_high(st);
        wcyc(HALF / 2);
        b = sda_bus;
        wcyc(HALF - HALF / 2);
        m_scl_lo = 1'b1;
    endtask

    task automatic bus_start();
        int st;
        m_sda_lo = 1'b0;
        wcyc(HALF);
        clk_high(st);
        wcyc(HALF);
        m_sda_lo = 1'b1;
        wcyc(HALF);
        m_scl_lo = 1'b1;
        wcyc(HALF);
    endtask

    task automatic bus_stop();
        int st;
        m_sda_lo = 1'b1;
        wcyc(HALF);
        clk_high(st);
        wcyc(HALF);
        m_sda_lo = 1'b0;
        wcyc(HALF);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack);
        int st;
        logic [7:0] b = {a, rw};
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(ack, st);
    endtask

    // receives one byte; checks the empty flag after the first bit
    task automatic read_byte(output logic [7:0] got, output int st0);
        logic b;
        int st;
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b, st);
            if (i == 0) begin
                st0 = st;
                wcyc(8);
                check("R5 empty after first bit", int'(st_empty), 1);
                check("R5 irq_tx after first bit", int'(irq_tx), int'(txi_en));
            end
            got = {got[6:0], b};
        end
    endtask

    task automatic expect_byte(input logic [7:0] got, input string req);
        logic [7:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        check(req, int'(got), int'(e));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        logic [7:0] got;
        int st;

        wcyc(5);
        rst_n = 1'b1;
        wcyc(5);

        // R12 reset state
        check("R12 scl_oe", int'(scl_oe), 0);
        check("R12 sda_oe", int'(sda_oe), 0);
        check("R12 st_empty", int'(st_empty), 1);
        check("R12 flags", int'({st_match, st_read, st_nak, st_stop}), 0);
        check("R12 irq_status", int'(irq_status), 0);

        // R5 interrupt gating
        txi_en = 1'b1; wcyc(1);
        check("R5 irq_tx with empty", int'(irq_tx), 1);
        txi_en = 1'b0; wcyc(1);

        // R6 write, flush, flush against write
        sw_write(8'h11);
        check("R6 write clears empty", int'(st_empty), 0);
        sw_flush();
        check("R6 flush sets empty", int'(st_empty), 1);
        flush = 1'b1; wr_en = 1'b1; wr_data = 8'h22; wcyc(1);
        flush = 1'b0; wr_en = 1'b0;
        check("R6 flush wins over write", int'(st_empty), 1);

        // R1/R2/R3/R4 read with stretch after address
        txi_en = 1'b1;
        bus_start();
        send_addr(7'h5A, 1'b1, ack);
        check("R1 read address acked", int'(ack), 0);
        check("R2 match", int'(st_match), 1);
        check("R2 read", int'(st_read), 1);
        check("R2 irq_status", int'(irq_status), 1);
        fork
            read_byte(got, st);
            begin
                wcyc(250);
                check("R3 SCL held while empty", int'(scl_oe), 1);
                sw_write(8'hA5);
            end
        join
        check("R3 stretch length", int'(st > 200), 1);
        expect_byte(got, "R4 first byte");

        // R7 register full at next byte: no stretch
        sw_write(8'h3C);
        check("R6 write clears empty", int'(st_empty), 0);
        send_bit(1'b0);
        read_byte(got, st);
        check("R7 no stretch when full", int'(st < 3), 1);
        expect_byte(got, "R4 second byte");

        // R7 register empty at next byte: stretch
        send_bit(1'b0);
        fork
            read_byte(got, st);
            begin
                wcyc(150);
                sw_write(8'hC3);
            end
        join
        check("R7 stretch when empty", int'(st > 100), 1);
        expect_byte(got, "R4 third byte");

        // R8 NAK
        send_bit(1'b1);
        wcyc(4);
        check("R8 nak flag", int'(st_nak), 1);
        check("R8 irq_status", int'(irq_status), 1);
        check("R8 SDA released", int'(sda_oe), 0);
        check("R9 no stop yet", int'(st_stop), 0);
        bus_stop();
        check("R9 stop flag", int'(st_stop), 1);

        // R11 clear
        sw_clear();
        check("R11 flags cleared", int'({st_match, st_read, st_nak, st_stop}), 0);
        check("R11 irq_status low", int'(irq_status), 0);

        // R1/R2 write direction to own address
        bus_start();
        send_addr(7'h5A, 1'b0, ack);
        check("R1 write not acked", int'(ack), 1);
        check("R2 match on write", int'(st_match), 1);
        check("R2 read low on write", int'(st_read), 0);
        bus_stop();
        check("R9 no stop without read hit", int'(st_stop), 0);
        sw_clear();

        // R1 foreign address
        bus_start();
        send_addr(7'h33, 1'b1, ack);
        check("R1 foreign not acked", int'(ack), 1);
        check("R1 foreign no match", int'(st_match), 0);
        bus_stop();

        // R10 general call disabled then enabled
        bus_start();
        send_addr(7'h00, 1'b1, ack);
        check("R10 gcall off not acked", int'(ack), 1);
        bus_stop();
        sw_write(8'h96);
        gc_en = 1'b1;
        bus_start();
        send_addr(7'h00, 1'b1, ack);
        check("R10 gcall on acked", int'(ack), 0);
        check("R10 gcall match", int'(st_match), 1);
        read_byte(got, st);
        check("R7 no stretch when preloaded", int'(st < 3), 1);
        expect_byte(got, "R4 gcall byte");
        send_bit(1'b1);

        // R9 repeated START ends the transfer
        bus_start();
        check("R9 restart flag", int'(st_stop), 1);
        send_addr(7'h33, 1'b1, ack);
        check("R1 foreign after restart", int'(ack), 1);
        bus_stop();

        check("R4 SDA changes with SCL high", sda_viol, 0);
        check("R5 per-clock irq model", irq_viol, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule